// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block holds the 16-bit stack pointer of a small 8-bit processor core. The stack grows toward lower addresses, and the pointer always marks the current top. The core raises one of four one-hot strobes: byte push, byte pop, return-address push (call or interrupt entry) and return-address pop (subroutine or interrupt return). For each strobe the unit drives the data-memory address, a write or read strobe and a byte-lane tag, then moves the pointer by one for a data byte or by two for a return address.

A return-address move takes two memory beats over two cycles. A small sequencer with three states carries it: `SEQ_IDLE` (accepts strobes; byte operations finish here in one cycle), `SEQ_CALL_TAIL` (second write beat of a return-address push) and `SEQ_RET_TAIL` (second read beat of a return-address pop). The transitions are: idle to call-tail on a return push, idle to ret-tail on a return pop, and either tail back to idle unconditionally. A push writes at the pointer and then decrements it. A pop increments first and reads at the new value. Both halves of the pointer register change in the same clock edge when a two-step move completes.

Software reaches the pointer as two byte-wide registers on an I/O register bus, with a separate address for each half. A write to either half wins over any stack strobe in the same cycle. A flag warns when the pointer sits at or below the lowest valid stack address, 0x0060.

Top module: `stack_ptr_unit`

## Requirements
- R1: During and after reset all sixteen pointer bits are zero, `busy` is low and `sp_low` is high.
- R2: In `SEQ_IDLE` a `push_byte` drives `mem_we` with `mem_addr` equal to the pointer in that cycle, and the pointer is one lower after the clock edge.
- R3: In `SEQ_IDLE` a `pop_byte` drives `mem_re` with `mem_addr` equal to pointer+1, and the pointer is one higher after the clock edge.
- R4: A `push_ret` writes two beats in consecutive cycles: address SP with `mem_byte`=0, then address SP-1 with `mem_byte`=1 while `busy` is high. The pointer is SP-2 after the second beat.
- R5: A `pop_ret` reads two beats in consecutive cycles: address SP+1 with `mem_byte`=1, then address SP+2 with `mem_byte`=0 while `busy` is high. The pointer is SP+2 after the second beat.
- R6: I/O address `LO_ADDR` (default 0x10) reads and writes pointer bits 7:0, and `HI_ADDR` (default 0x11) reads and writes bits 15:8. Reads are combinational. Any other address reads as zero, and a write to it leaves the pointer unchanged.
- R7: In `SEQ_IDLE` an I/O write to either pointer half in the same cycle as a stack strobe suppresses the strobe: no memory strobe, no state change, and only the written half changes.
- R8: An I/O write to a pointer half during a tail beat still lets that beat's memory access out, cancels the two-step adjustment, and loads the written half while the other half keeps its value.
- R9: Stack strobes that arrive during a tail state are ignored, and the sequencer always returns to `SEQ_IDLE` after one tail cycle.
- R10: Pointer arithmetic wraps modulo 2^16, and carries and borrows pass between the two byte halves.
- R11: `sp_low` is high exactly when the pointer is less than or equal to 0x0060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_byte | input | 1 | Push one data byte |
| pop_byte | input | 1 | Pop one data byte |
| push_ret | input | 1 | Push a two-byte return address |
| pop_ret | input | 1 | Pop a two-byte return address |
| io_we | input | 1 | I/O register write enable |
| io_addr | input | 6 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` |
| mem_addr | output | 16 | Data-memory address for the current stack beat |
| mem_we | output | 1 | Stack write beat |
| mem_re | output | 1 | Stack read beat |
| mem_byte | output | 1 | Return-address byte lane of the beat (0 low, 1 high) |
| busy | output | 1 | A tail beat is in progress |
| sp_value | output | 16 | Current pointer |
| sp_low | output | 1 | Pointer at or below 0x0060 |

## Verification
The hardest situation to reach is an I/O write that lands on the tail beat of a return-address move. The write must let the second memory beat out but cancel the two-step adjustment, while the other pointer half stays as it was. The bench reaches it by starting a return push or pop and then, on the very next falling edge, driving the I/O write together with the tail. It also sweeps all four stack operations over pointer values around zero, the 0x0060 floor, the byte boundary and the top of the address space, and works out each expected address and final pointer with arithmetic modulo 2^16.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_CALL_TAIL = 2'd1,
        SEQ_RET_TAIL  = 2'd2
    } seq_state_t;

    // which address the current beat uses
    typedef enum logic [1:0] {
        AD_SP    = 2'd0,
        AD_SP_M1 = 2'd1,
        AD_SP_P1 = 2'd2,
        AD_SP_P2 = 2'd3
    } addr_sel_t;

    // which adjusted pointer is committed
    typedef enum logic [1:0] {
        ST_DEC1 = 2'd0,
        ST_DEC2 = 2'd1,
        ST_INC1 = 2'd2,
        ST_INC2 = 2'd3
    } step_sel_t;

endpackage

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_byte,
    input  logic        pop_byte,
    input  logic        push_ret,
    input  logic        pop_ret,
    input  logic        io_hit,
    output logic        beat_we,
    output logic        beat_re,
    output logic        beat_byte,
    output addr_sel_t   addr_sel,
    output logic        step_en,
    output step_sel_t   step_sel,
    output logic        in_tail
);

    seq_state_t state_q;
    seq_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (!io_hit) begin
                    if (push_ret)     state_d = SEQ_CALL_TAIL;
                    else if (pop_ret) state_d = SEQ_RET_TAIL;
                end
            end
            SEQ_CALL_TAIL: state_d = SEQ_IDLE;
            SEQ_RET_TAIL:  state_d = SEQ_IDLE;
            default:       state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        beat_we   = 1'b0;
        beat_re   = 1'b0;
        beat_byte = 1'b0;
        addr_sel  = AD_SP;
        step_en   = 1'b0;
        step_sel  = ST_DEC1;
        in_tail   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (!io_hit) begin
                    if (push_byte) begin
                        beat_we  = 1'b1;
                        addr_sel = AD_SP;
                        step_en  = 1'b1;
                        step_sel = ST_DEC1;
                    end else if (pop_byte) begin
                        beat_re  = 1'b1;
                        addr_sel = AD_SP_P1;
                        step_en  = 1'b1;
                        step_sel = ST_INC1;
                    end else if (push_ret) begin
                        beat_we   = 1'b1;
                        beat_byte = 1'b0;
                        addr_sel  = AD_SP;
                    end else if (pop_ret) begin
                        beat_re   = 1'b1;
                        beat_byte = 1'b1;
                        addr_sel  = AD_SP_P1;
                    end
                end
            end
            SEQ_CALL_TAIL: begin
                in_tail   = 1'b1;
                beat_we   = 1'b1;
                beat_byte = 1'b1;
                addr_sel  = AD_SP_M1;
                step_en   = !io_hit;
                step_sel  = ST_DEC2;
            end
            SEQ_RET_TAIL: begin
                in_tail   = 1'b1;
                beat_re   = 1'b1;
                beat_byte = 1'b0;
                addr_sel  = AD_SP_P2;
                step_en   = !io_hit;
                step_sel  = ST_INC2;
            end
            default: begin
                in_tail = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sp_path.sv
module sp_path
    import sp_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0] sp,
    input  addr_sel_t       addr_sel,
    input  step_sel_t       step_sel,
    output logic [SP_W-1:0] beat_addr,
    output logic [SP_W-1:0] step_value
);

    localparam int N_OFS = 4;

    // adjusted pointers, index: 0 = -1, 1 = -2, 2 = +1, 3 = +2
    logic [SP_W-1:0] adj [N_OFS];

    for (genvar k = 0; k < N_OFS; k++) begin : g_adj
        localparam logic [SP_W-1:0] MAG = SP_W'(k % 2 + 1);
        if (k < 2) begin : g_dn
            assign adj[k] = sp - MAG;
        end else begin : g_up
            assign adj[k] = sp + MAG;
        end
    end

    always_comb begin
        unique case (addr_sel)
            AD_SP:    beat_addr = sp;
            AD_SP_M1: beat_addr = adj[0];
            AD_SP_P1: beat_addr = adj[2];
            AD_SP_P2: beat_addr = adj[3];
            default:  beat_addr = sp;
        endcase
    end

    always_comb begin
        unique case (step_sel)
            ST_DEC1: step_value = adj[0];
            ST_DEC2: step_value = adj[1];
            ST_INC1: step_value = adj[2];
            ST_INC2: step_value = adj[3];
            default: step_value = sp;
        endcase
    end

endmodule

// File: rtl/sp_regs.sv
module sp_regs #(
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [7:0]      wdata,
    input  logic            step_en,
    input  logic [SP_W-1:0] step_value,
    output logic [SP_W-1:0] sp,
    output logic [7:0]      lo_byte,
    output logic [7:0]      hi_byte
);

    localparam int HI_W = SP_W - 8;

    logic [7:0]      lo_q;
    logic [HI_W-1:0] hi_q;

    // an I/O write to either half freezes the stack step for both halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata[HI_W-1:0];
        end else if (step_en) begin
            lo_q <= step_value[7:0];
            hi_q <= step_value[SP_W-1:8];
        end
    end

    assign sp      = {hi_q, lo_q};
    assign lo_byte = lo_q;

    always_comb begin
        hi_byte           = '0;
        hi_byte[HI_W-1:0] = hi_q;
    end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import sp_pkg::*;
#(
    parameter int              SP_W    = 16,
    parameter int              IO_AW   = 6,
    parameter logic [IO_AW-1:0] LO_ADDR = 6'h10,
    parameter logic [IO_AW-1:0] HI_ADDR = 6'h11,
    parameter logic [SP_W-1:0] FLOOR   = 16'h0060
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_byte,
    input  logic             pop_byte,
    input  logic             push_ret,
    input  logic             pop_ret,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic [SP_W-1:0]  mem_addr,
    output logic             mem_we,
    output logic             mem_re,
    output logic             mem_byte,
    output logic             busy,
    output logic [SP_W-1:0]  sp_value,
    output logic             sp_low
);

    logic            sel_lo;
    logic            sel_hi;
    logic            wr_lo;
    logic            wr_hi;
    logic            io_hit;
    addr_sel_t       addr_sel;
    step_sel_t       step_sel;
    logic            step_en;
    logic [SP_W-1:0] step_value;
    logic [SP_W-1:0] sp;
    logic [7:0]      lo_byte;
    logic [7:0]      hi_byte;

    assign sel_lo = (io_addr == LO_ADDR);
    assign sel_hi = (io_addr == HI_ADDR);
    assign wr_lo  = io_we && sel_lo;
    assign wr_hi  = io_we && sel_hi;
    assign io_hit = wr_lo || wr_hi;

    sp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_byte (push_byte),
        .pop_byte  (pop_byte),
        .push_ret  (push_ret),
        .pop_ret   (pop_ret),
        .io_hit    (io_hit),
        .beat_we   (mem_we),
        .beat_re   (mem_re),
        .beat_byte (mem_byte),
        .addr_sel  (addr_sel),
        .step_en   (step_en),
        .step_sel  (step_sel),
        .in_tail   (busy)
    );

    sp_path #(.SP_W(SP_W)) u_path (
        .sp         (sp),
        .addr_sel   (addr_sel),
        .step_sel   (step_sel),
        .beat_addr  (mem_addr),
        .step_value (step_value)
    );

    sp_regs #(.SP_W(SP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (io_wdata),
        .step_en    (step_en),
        .step_value (step_value),
        .sp         (sp),
        .lo_byte    (lo_byte),
        .hi_byte    (hi_byte)
    );

    always_comb begin
        io_rdata = '0;
        if (sel_lo)      io_rdata = lo_byte;
        else if (sel_hi) io_rdata = hi_byte;
    end

    assign sp_value = sp;
    assign sp_low   = (sp <= FLOOR);

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
    parameter int               SP_W    = 16,
    parameter int               IO_AW   = 6,
    parameter logic [IO_AW-1:0] LO_ADDR = 6'h10,
    parameter logic [IO_AW-1:0] HI_ADDR = 6'h11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_byte,
    input logic             pop_byte,
    input logic             push_ret,
    input logic             pop_ret,
    input logic             io_we,
    input logic [IO_AW-1:0] io_addr,
    input logic [SP_W-1:0]  mem_addr,
    input logic             mem_we,
    input logic             mem_re,
    input logic             mem_byte,
    input logic             busy,
    input logic [SP_W-1:0]  sp_value
);

    logic io_hit_c;
    assign io_hit_c = io_we && (io_addr == LO_ADDR || io_addr == HI_ADDR);

    // R2
    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_byte && !io_hit_c) |=> sp_value == $past(sp_value) - 1'b1);

    // R3
    p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push_byte && pop_byte && !io_hit_c) |=> sp_value == $past(sp_value) + 1'b1);

    // R4
    p_call_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push_byte && !pop_byte && push_ret && !io_hit_c)
        |=> busy && mem_we && mem_byte && mem_addr == $past(sp_value) - 1'b1);

    // R5
    p_ret_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push_byte && !pop_byte && !push_ret && pop_ret && !io_hit_c)
        |=> busy && mem_re && !mem_byte && mem_addr == $past(sp_value) + 2'd2);

    // R7
    p_io_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && io_hit_c) |-> (!mem_we && !mem_re));

    // R9
    p_tail_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_hit_c && !mem_we && !mem_re) |=> $stable(sp_value));

    // R4, R5: exactly one direction per beat
    p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

bind stack_ptr_unit sp_unit_chk #(
    .SP_W(SP_W), .IO_AW(IO_AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .push_byte(push_byte), .pop_byte(pop_byte),
    .push_ret(push_ret), .pop_ret(pop_ret), .io_we(io_we), .io_addr(io_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_byte(mem_byte),
    .busy(busy), .sp_value(sp_value)
);

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;

    localparam logic [5:0] LO_A = 6'h10;
    localparam logic [5:0] HI_A = 6'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_byte = 1'b0;
    logic        pop_byte = 1'b0;
    logic        push_ret = 1'b0;
    logic        pop_ret = 1'b0;
    logic        io_we = 1'b0;
    logic [5:0]  io_addr = 6'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic        mem_byte;
    logic        busy;
    logic [15:0] sp_value;
    logic        sp_low;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    stack_ptr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_byte(push_byte), .pop_byte(pop_byte),
        .push_ret(push_ret), .pop_ret(pop_ret),
        .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_byte(mem_byte),
        .busy(busy), .sp_value(sp_value), .sp_low(sp_low)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        io_we = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        io_write(LO_A, v[7:0]);
        io_write(HI_A, v[15:8]);
    endtask

    task automatic check_sp(input string req, input logic [15:0] exp);
        #1;
        chk(req, sp_value, exp);
        chk("R11", {15'd0, sp_low}, {15'd0, exp <= 16'h0060});
    endtask

    // op: 0 byte push, 1 byte pop, 2 return push, 3 return pop
    task automatic run_op(input int op, input logic [15:0] s);
        logic [15:0] exp_end;
        load(s);
        @(negedge clk);
        push_byte = (op == 0); pop_byte = (op == 1);
        push_ret  = (op == 2); pop_ret  = (op == 3);
        #1;
        case (op)
            0: begin chk("R2", mem_addr, s);       chk("R2", {15'd0, mem_we}, 16'd1); exp_end = s - 16'd1; end
            1: begin chk("R3", mem_addr, s + 16'd1); chk("R3", {15'd0, mem_re}, 16'd1); exp_end = s + 16'd1; end
            2: begin chk("R4", mem_addr, s);       chk("R4", {15'd0, mem_byte}, 16'd0); exp_end = s - 16'd2; end
            default: begin chk("R5", mem_addr, s + 16'd1); chk("R5", {15'd0, mem_byte}, 16'd1); exp_end = s + 16'd2; end
        endcase
        @(negedge clk);
        push_byte = 1'b0; pop_byte = 1'b0; push_ret = 1'b0; pop_ret = 1'b0;
        if (op >= 2) begin
            #1;
            chk(op == 2 ? "R4" : "R5", {15'd0, busy}, 16'd1);
            if (op == 2) begin
                chk("R4", mem_addr, s - 16'd1);
                chk("R4", {14'd0, mem_we, mem_byte}, 16'd3);
            end else begin
                chk("R5", mem_addr, s + 16'd2);
                chk("R5", {14'd0, mem_re, mem_byte}, 16'd2);
            end
            @(negedge clk);
        end
        check_sp("R10", exp_end);
        chk("R9", {15'd0, busy}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] pts [12];
        pts = '{16'h0000, 16'h0001, 16'h005F, 16'h0060, 16'h0061, 16'h0062,
                16'h00FF, 16'h0100, 16'h0101, 16'h7FFF, 16'hFFFE, 16'hFFFF};

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1", sp_value, 16'h0000);
        chk("R1", {15'd0, busy}, 16'd0);
        chk("R1", {15'd0, sp_low}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", sp_value, 16'h0000);
        chk("R1", {15'd0, mem_we | mem_re}, 16'd0);

        // R6: byte register access
        load(16'hA55A);
        io_addr = LO_A; #1; chk("R6", {8'd0, io_rdata}, 16'h005A);
        io_addr = HI_A; #1; chk("R6", {8'd0, io_rdata}, 16'h00A5);
        io_addr = 6'h20; #1; chk("R6", {8'd0, io_rdata}, 16'h0000);
        io_write(6'h20, 8'h33);
        check_sp("R6", 16'hA55A);

        // sweep all operations over the boundary points (R2..R5, R10, R11)
        for (int i = 0; i < 12; i++) begin
            for (int op = 0; op < 4; op++) begin
                run_op(op, pts[i]);
            end
        end

        // R7: I/O write in idle blocks a stack strobe
        load(16'h0400);
        @(negedge clk);
        io_we = 1'b1; io_addr = HI_A; io_wdata = 8'h12; push_byte = 1'b1;
        #1;
        chk("R7", {14'd0, mem_we, mem_re}, 16'd0);
        @(negedge clk);
        io_we = 1'b0; push_byte = 1'b0;
        check_sp("R7", 16'h1200);
        chk("R7", {15'd0, busy}, 16'd0);
        @(negedge clk);
        io_we = 1'b1; io_addr = LO_A; io_wdata = 8'h77; pop_ret = 1'b1;
        #1;
        chk("R7", {14'd0, mem_we, mem_re}, 16'd0);
        @(negedge clk);
        io_we = 1'b0; pop_ret = 1'b0;
        #1;
        chk("R7", {15'd0, busy}, 16'd0);
        check_sp("R7", 16'h1277);

        // R8: I/O write lands on the tail of a return push
        load(16'h0200);
        @(negedge clk);
        push_ret = 1'b1;
        @(negedge clk);
        push_ret = 1'b0;
        io_we = 1'b1; io_addr = LO_A; io_wdata = 8'h55;
        #1;
        chk("R8", mem_addr, 16'h01FF);
        chk("R8", {15'd0, mem_we}, 16'd1);
        @(negedge clk);
        io_we = 1'b0;
        check_sp("R8", 16'h0255);

        // R8: I/O write on the tail of a return pop, high half
        load(16'h03FF);
        @(negedge clk);
        pop_ret = 1'b1;
        @(negedge clk);
        pop_ret = 1'b0;
        io_we = 1'b1; io_addr = HI_A; io_wdata = 8'h09;
        #1;
        chk("R8", mem_addr, 16'h0401);
        chk("R8", {15'd0, mem_re}, 16'd1);
        @(negedge clk);
        io_we = 1'b0;
        check_sp("R8", 16'h09FF);

        // R9: strobes during a tail are ignored
        load(16'h0300);
        @(negedge clk);
        push_ret = 1'b1;
        @(negedge clk);
        push_ret = 1'b0; pop_byte = 1'b1;
        @(negedge clk);
        pop_byte = 1'b0;
        #1;
        chk("R9", {13'd0, busy, mem_we, mem_re}, 16'd0);
        check_sp("R9", 16'h02FE);
        @(negedge clk);
        check_sp("R9", 16'h02FE);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule